// File: doc/BRIEF.md
# Multi-Row Open Page Tracker

This block sits beside an SDRAM command scheduler and records which page is currently open in every bank of every populated memory row. Before the scheduler issues a read or write, it presents the target row, bank and page address. One cycle later the tracker answers with one of three outcomes: the page is already open (hit), another page is open in that bank and must be closed first (miss, with that page's address), or nothing is open in that bank (empty).

The scheduler keeps the table current by reporting each activate and precharge it issues. A precharge can close one bank or every bank of a row. Each row is set up as built from 4-bank or 2-bank devices. A 2-bank row has only its two lower bank slots. A policy input selects open-page operation, where pages stay open, or closed-page operation, where nothing is ever tracked. Command timing and arbitration belong to the scheduler, not to this block.

Top module: `opt_page_tracker`

## Requirements
- R1: After reset every bank slot is closed and `res_valid` is low. A lookup issued before any activate reports empty.
- R2: A lookup presented with `lk_valid` high produces `res_valid` high on the next cycle and low on the cycle after, unless another lookup follows. `res_kind` encodes empty as 2'b00, hit as 2'b01 and miss as 2'b10. The code 2'b11 never appears.
- R3: In open-page mode, an activate to a legal row and bank records its page. A later lookup of the same row, bank and page reports hit, with `res_victim` equal to 0.
- R4: A lookup of a recorded bank with a different page reports miss, with `res_victim` equal to the recorded page. Every non-miss result has `res_victim` equal to 0.
- R5: Slots in different rows and different banks are independent. All four rows can hold open pages at the same time.
- R6: A row whose `row_is_4bank` bit is 1 holds four open pages at once, one in each of banks 0 to 3.
- R7: In a row whose `row_is_4bank` bit is 0, activates to banks 2 and 3 are ignored and leave no entry. Lookups to those banks report empty, even for a page given in such an activate.
- R8: A precharge with `pre_all` low closes only the addressed bank of the addressed row.
- R9: A precharge with `pre_all` high closes every bank of the addressed row and leaves all other rows unchanged.
- R10: While `keep_open` is low, every lookup reports empty, activates record nothing, and all slots are cleared. After `keep_open` returns high, lookups report empty until new activates arrive.
- R11: A lookup uses the table as it stood before the updates of its own cycle. When an activate and a precharge hit the same slot in the same cycle, the activate wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| keep_open | input | 1 | 1 = open-page policy, 0 = closed-page policy |
| row_is_4bank | input | NUM_ROWS | Per row: 1 = 4-bank devices, 0 = 2-bank devices |
| act_valid | input | 1 | Activate notification strobe |
| act_row | input | ROW_W | Row of the activate |
| act_bank | input | BANK_W | Bank of the activate |
| act_page | input | PAGE_W | Page opened by the activate |
| pre_valid | input | 1 | Precharge notification strobe |
| pre_row | input | ROW_W | Row of the precharge |
| pre_bank | input | BANK_W | Bank of a single-bank precharge |
| pre_all | input | 1 | 1 = close all banks of `pre_row` |
| lk_valid | input | 1 | Lookup request strobe |
| lk_row | input | ROW_W | Row of the lookup |
| lk_bank | input | BANK_W | Bank of the lookup |
| lk_page | input | PAGE_W | Page the access targets |
| res_valid | output | 1 | Lookup result valid, one cycle after the request |
| res_kind | output | 2 | 00 empty, 01 hit, 10 miss |
| res_victim | output | PAGE_W | Page to close on a miss, otherwise 0 |

## Verification
The checker follows properties on every cycle. It checks the one-cycle result latency and the legal outcome codes. It checks that the victim address is zero outside a miss and that every slot is flushed after a closed-page cycle. It also checks that closed-page and narrow-row lookups come back empty and that a legal open-page activate leaves its slot valid. Whether a stored page is actually compared is left to the bench's scenarios. The same goes for the exact victim address on a miss, the reach of single-bank versus whole-row precharge, the independence of rows, and the same-cycle ordering of lookup, activate and precharge. Those come from directed sequences with expected outcomes.

// File: rtl/opt_pkg.sv
// Shared constants and the lookup outcome type for the open page tracker.
package opt_pkg;
    localparam int OPT_ROWS   = 4;
    localparam int OPT_BANKS  = 4;
    localparam int OPT_PAGE_W = 13;

    typedef enum logic [1:0] {
        PG_EMPTY = 2'b00,
        PG_HIT   = 2'b01,
        PG_MISS  = 2'b10
    } opt_kind_e;
endpackage

// File: rtl/opt_slot.sv
// One tracked bank slot: a valid flag plus the open page address.
// Assumes set and clear come from the command decoder; set has priority.
module opt_slot #(
    parameter int PAGE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              valid_o,
    output logic [PAGE_W-1:0] page_o
);
    // Hold the open page; an activate overrides a same-cycle close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            page_o  <= '0;
        end else if (set_i) begin
            valid_o <= 1'b1;
            page_o  <= page_i;
        end else if (clr_i) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/opt_cmd_decode.sv
// Turns activate/precharge notifications and the policy into per-slot
// set and clear strobes. Slot index is row*MAX_BANKS+bank. Assumes
// MAX_BANKS is even; a 2-bank row only owns the lower half of its banks.
module opt_cmd_decode #(
    parameter int NUM_ROWS  = 4,
    parameter int MAX_BANKS = 4,
    localparam int ROW_W    = $clog2(NUM_ROWS),
    localparam int BANK_W   = $clog2(MAX_BANKS),
    localparam int N_SLOT   = NUM_ROWS * MAX_BANKS,
    localparam int HALF     = MAX_BANKS / 2
) (
    input  logic                keep_open,
    input  logic [NUM_ROWS-1:0] row_is_4bank,
    input  logic                act_valid,
    input  logic [ROW_W-1:0]    act_row,
    input  logic [BANK_W-1:0]   act_bank,
    input  logic                pre_valid,
    input  logic [ROW_W-1:0]    pre_row,
    input  logic [BANK_W-1:0]   pre_bank,
    input  logic                pre_all,
    output logic [N_SLOT-1:0]   set_vec,
    output logic [N_SLOT-1:0]   clr_vec
);
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
            localparam logic LOW_BANK = (b < HALF);
            logic legal, act_hit, pre_hit;
            // Upper banks exist only in rows built from 4-bank devices.
            assign legal   = LOW_BANK || row_is_4bank[r];
            // Activate addresses this slot.
            assign act_hit = act_valid && (act_row == ROW_W'(r)) && (act_bank == BANK_W'(b));
            // Precharge addresses this slot, singly or as part of its row.
            assign pre_hit = pre_valid && (pre_row == ROW_W'(r)) &&
                             (pre_all || (pre_bank == BANK_W'(b)));
            assign set_vec[r*MAX_BANKS+b] = keep_open && act_hit && legal;
            assign clr_vec[r*MAX_BANKS+b] = !keep_open || pre_hit;
        end
    end
endmodule

// File: rtl/opt_lookup.sv
// Classifies a lookup against the slot table and registers the outcome.
// Assumes NUM_ROWS and MAX_BANKS are powers of two so {row,bank} is the
// slot index. The table is sampled before that cycle's updates land.
module opt_lookup
    import opt_pkg::*;
#(
    parameter int NUM_ROWS  = 4,
    parameter int MAX_BANKS = 4,
    parameter int PAGE_W    = 13,
    localparam int ROW_W    = $clog2(NUM_ROWS),
    localparam int BANK_W   = $clog2(MAX_BANKS),
    localparam int N_SLOT   = NUM_ROWS * MAX_BANKS,
    localparam int HALF     = MAX_BANKS / 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            keep_open,
    input  logic [NUM_ROWS-1:0]             row_is_4bank,
    input  logic [N_SLOT-1:0]               slot_valid,
    input  logic [N_SLOT-1:0][PAGE_W-1:0]   slot_page,
    input  logic                            lk_valid,
    input  logic [ROW_W-1:0]                lk_row,
    input  logic [BANK_W-1:0]               lk_bank,
    input  logic [PAGE_W-1:0]               lk_page,
    output logic                            res_valid,
    output opt_kind_e                       res_kind,
    output logic [PAGE_W-1:0]               res_victim
);
    logic [ROW_W+BANK_W-1:0] idx;
    logic                    sel_valid, legal;
    logic [PAGE_W-1:0]       sel_page;
    opt_kind_e               kind_d;
    logic [PAGE_W-1:0]       victim_d;

    assign idx       = {lk_row, lk_bank};
    assign sel_valid = slot_valid[idx];
    assign sel_page  = slot_page[idx];
    assign legal     = row_is_4bank[lk_row] || (lk_bank < BANK_W'(HALF));

    // Decide hit, miss or empty for the addressed slot.
    always_comb begin
        kind_d   = PG_EMPTY;
        victim_d = '0;
        if (keep_open && legal && sel_valid) begin
            if (sel_page == lk_page) begin
                kind_d = PG_HIT;
            end else begin
                kind_d   = PG_MISS;
                victim_d = sel_page;
            end
        end
    end

    // Register the outcome; it is held between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_kind   <= PG_EMPTY;
            res_victim <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_kind   <= kind_d;
                res_victim <= victim_d;
            end
        end
    end
endmodule

// File: rtl/opt_page_tracker.sv
// Open page tracker: one slot per row and bank, updated by activate and
// precharge notifications and queried by lookups with one cycle latency.
// Assumes power-of-two row and bank counts and that the scheduler reports
// every activate and precharge it issues.
module opt_page_tracker
    import opt_pkg::*;
#(
    parameter int NUM_ROWS  = OPT_ROWS,
    parameter int MAX_BANKS = OPT_BANKS,
    parameter int PAGE_W    = OPT_PAGE_W,
    localparam int ROW_W    = $clog2(NUM_ROWS),
    localparam int BANK_W   = $clog2(MAX_BANKS),
    localparam int N_SLOT   = NUM_ROWS * MAX_BANKS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                keep_open,
    input  logic [NUM_ROWS-1:0] row_is_4bank,
    input  logic                act_valid,
    input  logic [ROW_W-1:0]    act_row,
    input  logic [BANK_W-1:0]   act_bank,
    input  logic [PAGE_W-1:0]   act_page,
    input  logic                pre_valid,
    input  logic [ROW_W-1:0]    pre_row,
    input  logic [BANK_W-1:0]   pre_bank,
    input  logic                pre_all,
    input  logic                lk_valid,
    input  logic [ROW_W-1:0]    lk_row,
    input  logic [BANK_W-1:0]   lk_bank,
    input  logic [PAGE_W-1:0]   lk_page,
    output logic                res_valid,
    output logic [1:0]          res_kind,
    output logic [PAGE_W-1:0]   res_victim
);
    logic [N_SLOT-1:0]             set_vec, clr_vec;
    logic [N_SLOT-1:0]             slot_valid;
    logic [N_SLOT-1:0][PAGE_W-1:0] slot_page;
    opt_kind_e                     kind_q;

    opt_cmd_decode #(
        .NUM_ROWS  (NUM_ROWS),
        .MAX_BANKS (MAX_BANKS)
    ) u_decode (
        .keep_open    (keep_open),
        .row_is_4bank (row_is_4bank),
        .act_valid    (act_valid),
        .act_row      (act_row),
        .act_bank     (act_bank),
        .pre_valid    (pre_valid),
        .pre_row      (pre_row),
        .pre_bank     (pre_bank),
        .pre_all      (pre_all),
        .set_vec      (set_vec),
        .clr_vec      (clr_vec)
    );

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        opt_slot #(.PAGE_W(PAGE_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_vec[s]),
            .clr_i   (clr_vec[s]),
            .page_i  (act_page),
            .valid_o (slot_valid[s]),
            .page_o  (slot_page[s])
        );
    end

    opt_lookup #(
        .NUM_ROWS  (NUM_ROWS),
        .MAX_BANKS (MAX_BANKS),
        .PAGE_W    (PAGE_W)
    ) u_lookup (
        .clk          (clk),
        .rst_n        (rst_n),
        .keep_open    (keep_open),
        .row_is_4bank (row_is_4bank),
        .slot_valid   (slot_valid),
        .slot_page    (slot_page),
        .lk_valid     (lk_valid),
        .lk_row       (lk_row),
        .lk_bank      (lk_bank),
        .lk_page      (lk_page),
        .res_valid    (res_valid),
        .res_kind     (kind_q),
        .res_victim   (res_victim)
    );

    assign res_kind = kind_q;
endmodule

// File: rtl/opt_page_tracker_chk.sv
// Property checker for the open page tracker, bound into every instance.
module opt_page_tracker_chk
    import opt_pkg::*;
#(
    parameter int NUM_ROWS  = 4,
    parameter int MAX_BANKS = 4,
    parameter int PAGE_W    = 13,
    localparam int ROW_W    = $clog2(NUM_ROWS),
    localparam int BANK_W   = $clog2(MAX_BANKS),
    localparam int N_SLOT   = NUM_ROWS * MAX_BANKS,
    localparam int HALF     = MAX_BANKS / 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                keep_open,
    input logic [NUM_ROWS-1:0] row_is_4bank,
    input logic                act_valid,
    input logic [ROW_W-1:0]    act_row,
    input logic [BANK_W-1:0]   act_bank,
    input logic                lk_valid,
    input logic [ROW_W-1:0]    lk_row,
    input logic [BANK_W-1:0]   lk_bank,
    input logic                res_valid,
    input logic [1:0]          res_kind,
    input logic [PAGE_W-1:0]   res_victim,
    input logic [N_SLOT-1:0]   slot_valid
);
    logic past_ok;

    // Marks that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (res_valid == $past(lk_valid))); // R2
    AST_KIND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_kind != 2'b11)); // R2
    AST_VICTIM_ONLY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind != PG_MISS) |-> (res_victim == '0)); // R4
    AST_CLOSED_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!keep_open)) |-> (slot_valid == '0)); // R10
    AST_CLOSED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && res_valid && $past(!keep_open)) |-> (res_kind == PG_EMPTY)); // R10
    AST_NARROW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && res_valid && $past(!row_is_4bank[lk_row] && (lk_bank >= BANK_W'(HALF))))
        |-> (res_kind == PG_EMPTY)); // R7
    AST_ACT_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(act_valid && keep_open &&
                          (row_is_4bank[act_row] || (act_bank < BANK_W'(HALF)))))
        |-> slot_valid[$past({act_row, act_bank})]); // R3
endmodule

bind opt_page_tracker opt_page_tracker_chk #(
    .NUM_ROWS  (NUM_ROWS),
    .MAX_BANKS (MAX_BANKS),
    .PAGE_W    (PAGE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .keep_open    (keep_open),
    .row_is_4bank (row_is_4bank),
    .act_valid    (act_valid),
    .act_row      (act_row),
    .act_bank     (act_bank),
    .lk_valid     (lk_valid),
    .lk_row       (lk_row),
    .lk_bank      (lk_bank),
    .res_valid    (res_valid),
    .res_kind     (res_kind),
    .res_victim   (res_victim),
    .slot_valid   (slot_valid)
);

// File: tb/opt_page_tracker_bench.sv
// Directed bench for the open page tracker: one task per scenario.
module opt_page_tracker_bench;
    localparam int PW = 13;
    localparam logic [1:0] K_EMPTY = 2'b00, K_HIT = 2'b01, K_MISS = 2'b10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          keep_open = 1'b1;
    logic [3:0]    row_is_4bank = 4'b1011;
    logic          act_valid = 1'b0, pre_valid = 1'b0, pre_all = 1'b0, lk_valid = 1'b0;
    logic [1:0]    act_row = '0, act_bank = '0, pre_row = '0, pre_bank = '0;
    logic [1:0]    lk_row = '0, lk_bank = '0;
    logic [PW-1:0] act_page = '0, lk_page = '0;
    logic          res_valid;
    logic [1:0]    res_kind;
    logic [PW-1:0] res_victim;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    opt_page_tracker u_opt_page_tracker (
        .clk(clk), .rst_n(rst_n), .keep_open(keep_open), .row_is_4bank(row_is_4bank),
        .act_valid(act_valid), .act_row(act_row), .act_bank(act_bank), .act_page(act_page),
        .pre_valid(pre_valid), .pre_row(pre_row), .pre_bank(pre_bank), .pre_all(pre_all),
        .lk_valid(lk_valid), .lk_row(lk_row), .lk_bank(lk_bank), .lk_page(lk_page),
        .res_valid(res_valid), .res_kind(res_kind), .res_victim(res_victim)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_act(input int r, input int b, input int p);
        act_valid = 1'b1; act_row = 2'(r); act_bank = 2'(b); act_page = PW'(p);
    endtask

    task automatic set_pre(input int r, input int b, input bit all);
        pre_valid = 1'b1; pre_row = 2'(r); pre_bank = 2'(b); pre_all = all;
    endtask

    task automatic set_lk(input int r, input int b, input int p);
        lk_valid = 1'b1; lk_row = 2'(r); lk_bank = 2'(b); lk_page = PW'(p);
    endtask

    // Advance one cycle and drop all strobes.
    task automatic step();
        @(negedge clk);
        act_valid = 1'b0; pre_valid = 1'b0; pre_all = 1'b0; lk_valid = 1'b0;
    endtask

    task automatic do_act(input int r, input int b, input int p);
        set_act(r, b, p); step();
    endtask

    task automatic do_pre(input int r, input int b, input bit all);
        set_pre(r, b, all); step();
    endtask

    // Issue a lookup and compare the result seen after the capturing edge.
    task automatic expect_lk(input int r, input int b, input int p,
                             input logic [1:0] kind, input int victim, input string req);
        set_lk(r, b, p); step();
        chk(res_valid == 1'b1, req, "res_valid", res_valid, 1);
        chk(res_kind == kind, req, "res_kind", res_kind, kind);
        chk(res_victim == PW'(victim), req, "res_victim", res_victim, victim);
    endtask

    task automatic t_reset();
        chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        expect_lk(0, 0, 5, K_EMPTY, 0, "R1");
    endtask

    task automatic t_latency();
        set_lk(1, 1, 3); step();
        chk(res_valid == 1'b1, "R2", "valid one cycle later", res_valid, 1);
        step();
        chk(res_valid == 1'b0, "R2", "valid drops after one cycle", res_valid, 0);
    endtask

    task automatic t_hit_miss();
        do_act(0, 1, 'h123);
        expect_lk(0, 1, 'h123, K_HIT, 0, "R3");
        expect_lk(0, 1, 'h456, K_MISS, 'h123, "R4");
    endtask

    task automatic t_rows();
        do_act(1, 0, 'h11);
        do_act(2, 1, 'h22);
        do_act(3, 0, 'h33);
        expect_lk(1, 0, 'h11, K_HIT, 0, "R5");
        expect_lk(2, 1, 'h22, K_HIT, 0, "R5");
        expect_lk(3, 0, 'h33, K_HIT, 0, "R5");
        expect_lk(3, 1, 'h33, K_EMPTY, 0, "R5");
        expect_lk(0, 1, 'h123, K_HIT, 0, "R5");
    endtask

    task automatic t_four_bank();
        for (int b = 0; b < 4; b++) do_act(3, b, 'h40 + b);
        for (int b = 0; b < 4; b++) expect_lk(3, b, 'h40 + b, K_HIT, 0, "R6");
    endtask

    task automatic t_two_bank();
        do_act(2, 2, 'h77);
        do_act(2, 3, 'h78);
        expect_lk(2, 2, 'h77, K_EMPTY, 0, "R7");
        expect_lk(2, 3, 'h78, K_EMPTY, 0, "R7");
        expect_lk(2, 0, 'h77, K_EMPTY, 0, "R7");
        expect_lk(2, 1, 'h22, K_HIT, 0, "R7");
        row_is_4bank[2] = 1'b1;
        expect_lk(2, 2, 'h77, K_EMPTY, 0, "R7");
        row_is_4bank[2] = 1'b0;
    endtask

    task automatic t_precharge();
        do_pre(3, 1, 1'b0);
        expect_lk(3, 1, 'h41, K_EMPTY, 0, "R8");
        expect_lk(3, 0, 'h40, K_HIT, 0, "R8");
        expect_lk(3, 2, 'h42, K_HIT, 0, "R8");
    endtask

    task automatic t_precharge_all();
        do_pre(3, 2, 1'b1);
        expect_lk(3, 0, 'h40, K_EMPTY, 0, "R9");
        expect_lk(3, 3, 'h43, K_EMPTY, 0, "R9");
        expect_lk(1, 0, 'h11, K_HIT, 0, "R9");
    endtask

    task automatic t_same_cycle();
        set_lk(1, 2, 'h99); set_act(1, 2, 'h99); step();
        chk(res_kind == K_EMPTY, "R11", "lookup sees old table", res_kind, K_EMPTY);
        expect_lk(1, 2, 'h99, K_HIT, 0, "R11");
        set_act(1, 3, 'h55); set_pre(1, 3, 1'b0); step();
        expect_lk(1, 3, 'h55, K_HIT, 0, "R11");
    endtask

    task automatic t_closed();
        keep_open = 1'b0;
        step();
        expect_lk(0, 1, 'h123, K_EMPTY, 0, "R10");
        do_act(0, 2, 'h10);
        expect_lk(0, 2, 'h10, K_EMPTY, 0, "R10");
        keep_open = 1'b1;
        expect_lk(0, 1, 'h123, K_EMPTY, 0, "R10");
        expect_lk(0, 2, 'h10, K_EMPTY, 0, "R10");
        expect_lk(1, 0, 'h11, K_EMPTY, 0, "R10");
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_latency();
        t_hit_miss();
        t_rows();
        t_four_bank();
        t_two_bank();
        t_precharge();
        t_precharge_all();
        t_same_cycle();
        t_closed();
        step();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule